// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a line that rests high. A one-cycle start strobe, seen while the block is idle, latches the character and the frame settings: 5 to 8 data bits, parity off, even or odd, and a stop interval of one, one and a half, or two bit periods. The block then sends a low start bit, the data bits least significant first, the optional parity bit and the high stop interval. The settings can therefore change from one character to the next.

The bit period is a whole number of clock cycles set by the parameter `CLKS_PER_BIT`. For example, a 50 MHz clock at 9600 baud gives 5208 cycles per bit. The block holds `busy_o` high for the whole frame and raises `done_o` for one clock when the stop interval has ended. A start strobe in that same cycle opens the next frame without an idle gap. The serial output comes straight from a flip-flop.

Top module: `serial_frame_tx`

## Requirements
- R1: When no frame is in progress, `tx_o` is 1, `busy_o` is 0 and `done_o` is 0. This holds from reset onward.
- R2: A strobe on `start_i` is accepted at a clock edge where the block is idle. From the cycle after that edge, `tx_o` is 0 for exactly `CLKS_PER_BIT` cycles.
- R3: The data bits follow the start bit, each for `CLKS_PER_BIT` cycles, bit 0 first. Their count is 5 + `len_sel_i`: code 0 gives 5 bits and code 3 gives 8 bits. Data bits above that count are not sent.
- R4: `par_sel_i` selects the parity: 1 is even, 2 is odd, and 0 or 3 sends no parity bit. The parity bit lasts one bit period after the last data bit. With it included, the count of ones over the sent data bits and the parity bit is even (code 1) or odd (code 2).
- R5: `tx_o` is 1 during the stop interval. The length of the interval depends on `stop_sel_i`: code 0 gives `CLKS_PER_BIT` cycles, code 1 gives `CLKS_PER_BIT + floor(CLKS_PER_BIT/2)` cycles, and codes 2 and 3 give `2*CLKS_PER_BIT` cycles.
- R6: `busy_o` is 1 from the cycle after acceptance until the last cycle of the stop interval.
- R7: In the cycle right after the stop interval, `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R8: The data and the three settings are sampled only at acceptance. Changing them during a frame leaves that frame unchanged.
- R9: A strobe on `start_i` while `busy_o` is 1 is ignored. The frame in progress continues unchanged, and no new frame starts from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to send one character |
| data_i | input | 8 | Character to send |
| len_sel_i | input | 2 | Data length code (bits = 5 + code) |
| par_sel_i | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 none |
| stop_sel_i | input | 2 | Stop code: 0 one bit, 1 one and a half bits, 2 or 3 two bits |
| tx_o | output | 1 | Serial line, high when idle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the stop interval |

## Verification
The bench builds the block with `CLKS_PER_BIT` set to 7. This keeps a frame under about 85 cycles, so every combination of length, parity and stop code fits within a short run. Because 7 is odd, the half-bit stop must come out as 10 cycles: a value that rounds up instead of down gives a different length, and the per-cycle scoreboard catches it. The small divisor also makes it cheap to send back-to-back frames and to change the inputs during a frame.

// File: rtl/sfx_pkg.sv
// Package: shared constants and encodings for the serial frame transmitter.
// Assumes: character width is 8 and the shortest data length is 5 bits.
package sfx_pkg;

    localparam int SFX_DATA_W   = 8;
    localparam int SFX_MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } sfx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } sfx_par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } sfx_stop_e;

endpackage

// File: rtl/sfx_bit_timer.sv
// Module: down-counter that measures the segments of a frame.
// A load sets the count to (segment length - 1). expire_o is high while
// the count is zero. The owner decides whether an expiry means anything.
// Assumes: load_val_i fits in CNT_W bits.
module sfx_bit_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

    // Segment lengths rely on a steady one-per-cycle decrement.
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sfx_parity.sv
// Module: parity bit over the data bits actually sent.
// Bits at or above (5 + len_sel_i) are masked off. The bit makes the total
// count of ones even, or odd when odd_i is set.
// Assumes: a purely combinational path fed from captured registers.
module sfx_parity
    import sfx_pkg::*;
(
    input  logic [SFX_DATA_W-1:0] data_i,
    input  logic [1:0]            len_sel_i,
    input  logic                  odd_i,
    output logic                  par_o
);

    logic [SFX_DATA_W-1:0] used;

    // One mask gate per data bit position.
    for (genvar g = 0; g < SFX_DATA_W; g++) begin : g_mask
        assign used[g] = data_i[g] & (g < SFX_MIN_BITS + int'(len_sel_i));
    end

    // Fold the kept bits and flip for odd mode.
    always_comb begin
        par_o = (^used) ^ odd_i;
    end

endmodule

// File: rtl/serial_frame_tx.sv
// Module: serialises one character per accepted start strobe onto an
// idle-high line. The frame is: start (0), 5..8 data bits LSB first,
// optional parity, and a high stop interval of 1, 1.5 or 2 bit periods.
// Assumes: CLKS_PER_BIT >= 2. Settings are captured at acceptance and a
// strobe while busy is ignored.
module serial_frame_tx
    import sfx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 5208
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    input  logic [1:0] len_sel_i,
    input  logic [1:0] par_sel_i,
    input  logic [1:0] stop_sel_i,
    output logic       tx_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int CNT_W = $clog2(2 * CLKS_PER_BIT);
    localparam int IDX_W = $clog2(SFX_DATA_W);
    localparam logic [CNT_W-1:0] LOAD_BIT  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] LOAD_1H   = CNT_W'(CLKS_PER_BIT + CLKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LOAD_TWO  = CNT_W'(2 * CLKS_PER_BIT - 1);

    sfx_state_e            state_q, state_d;
    logic [SFX_DATA_W-1:0] data_q;
    logic [1:0]            len_q;
    sfx_par_e              par_q;
    sfx_stop_e             stop_q;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic                  tx_q, tx_d;
    logic                  busy_q, busy_d;
    logic                  done_q, done_d;

    logic                  load;
    logic [CNT_W-1:0]      load_val;
    logic                  expire;
    logic                  par_bit;
    logic                  par_en;
    logic                  accept;
    logic [IDX_W-1:0]      last_idx;
    logic [CNT_W-1:0]      stop_load;

    sfx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    sfx_parity u_parity (
        .data_i    (data_q),
        .len_sel_i (len_q),
        .odd_i     (par_q == PAR_ODD),
        .par_o     (par_bit)
    );

    // Decode the captured settings into frame-shape values.
    always_comb begin
        last_idx = IDX_W'(SFX_MIN_BITS - 1) + IDX_W'(len_q);
        par_en   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
        accept   = (state_q == ST_IDLE) && start_i;
        case (stop_q)
            STOP_ONE:      stop_load = LOAD_BIT;
            STOP_ONE_HALF: stop_load = LOAD_1H;
            default:       stop_load = LOAD_TWO;
        endcase
    end

    // Step through the frame segments; each segment ends on timer expiry.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        tx_d     = tx_q;
        busy_d   = busy_q;
        done_d   = 1'b0;
        load     = 1'b0;
        load_val = LOAD_BIT;
        case (state_q)
            ST_IDLE: begin
                tx_d = 1'b1;
                if (start_i) begin
                    state_d = ST_START;
                    tx_d    = 1'b0;
                    busy_d  = 1'b1;
                    load    = 1'b1;
                end
            end
            ST_START: begin
                if (expire) begin
                    state_d = ST_DATA;
                    idx_d   = '0;
                    tx_d    = data_q[0];
                    load    = 1'b1;
                end
            end
            ST_DATA: begin
                if (expire) begin
                    load = 1'b1;
                    if (idx_q != last_idx) begin
                        idx_d = idx_q + 1'b1;
                        tx_d  = data_q[idx_d];
                    end else if (par_en) begin
                        state_d = ST_PARITY;
                        tx_d    = par_bit;
                    end else begin
                        state_d  = ST_STOP;
                        tx_d     = 1'b1;
                        load_val = stop_load;
                    end
                end
            end
            ST_PARITY: begin
                if (expire) begin
                    state_d  = ST_STOP;
                    tx_d     = 1'b1;
                    load     = 1'b1;
                    load_val = stop_load;
                end
            end
            ST_STOP: begin
                if (expire) begin
                    state_d = ST_IDLE;
                    tx_d    = 1'b1;
                    busy_d  = 1'b0;
                    done_d  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                tx_d    = 1'b1;
                busy_d  = 1'b0;
            end
        endcase
    end

    // Register state and the glitch-free line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            tx_q    <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            tx_q    <= tx_d;
            busy_q  <= busy_d;
            done_q  <= done_d;
        end
    end

    // Capture character and settings only at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            len_q  <= '0;
            par_q  <= PAR_NONE;
            stop_q <= STOP_ONE;
        end else if (accept) begin
            data_q <= data_i;
            len_q  <= len_sel_i;
            par_q  <= sfx_par_e'(par_sel_i);
            stop_q <= sfx_stop_e'(stop_sel_i);
        end
    end

    assign tx_o   = tx_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));

    assert_hold_settings_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !(state_q == ST_STOP && expire)) |=>
        ($stable(data_q) && $stable(len_q) && $stable(par_q) && $stable(stop_q)));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && state_q != ST_START) |=> (state_q != ST_START));

endmodule

// File: tb/serial_frame_tx_tb.sv
// Scoreboard bench: the driver pushes one expected {tx, busy, done} item per
// cycle; the monitor pops one per falling edge and compares.
module serial_frame_tx_tb;

    localparam int CPB = 7;

    typedef struct {
        logic  tx;
        logic  busy;
        logic  done;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] data_i = '0;
    logic [1:0] len_sel_i = '0;
    logic [1:0] par_sel_i = '0;
    logic [1:0] stop_sel_i = '0;
    logic       tx_o, busy_o, done_o;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   running = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    serial_frame_tx #(.CLKS_PER_BIT(CPB)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .data_i     (data_i),
        .len_sel_i  (len_sel_i),
        .par_sel_i  (par_sel_i),
        .stop_sel_i (stop_sel_i),
        .tx_o       (tx_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // Monitor: one comparison per cycle; idle is expected when nothing is queued (R1).
    always @(negedge clk) begin
        if (running) begin
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else cur = '{tx: 1'b1, busy: 1'b0, done: 1'b0, tag: "R1"};
            checks++;
            if ({tx_o, busy_o, done_o} !== {cur.tx, cur.busy, cur.done}) begin
                errors++;
                $display("FAIL %s at %0t: tx/busy/done=%b%b%b expected %b%b%b",
                         cur.tag, $time, tx_o, busy_o, done_o, cur.tx, cur.busy, cur.done);
            end
        end
    end

    task automatic push_n(input logic tx, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{tx: tx, busy: 1'b1, done: 1'b0, tag: tag});
    endtask

    // Driver: sends one frame, scrambles inputs after acceptance (R8), optionally
    // strobes start mid-frame (R9), and returns at the edge that ends the frame.
    task automatic send(input logic [7:0] d, input logic [1:0] len,
                        input logic [1:0] par, input logic [1:0] stp, input bit poke);
        int nbits, slen, total;
        logic pbit;
        string dtag;
        nbits = 5 + int'(len);
        slen  = (stp == 2'd0) ? CPB : (stp == 2'd1) ? (CPB + CPB / 2) : 2 * CPB;
        pbit  = 1'b0;
        for (int i = 0; i < nbits; i++) pbit ^= d[i];
        if (par == 2'd2) pbit = ~pbit;
        total = CPB * (1 + nbits + ((par == 2'd1 || par == 2'd2) ? 1 : 0)) + slen;
        dtag  = poke ? "R3/R8/R9" : "R3/R8";
        @(negedge clk);
        data_i = d; len_sel_i = len; par_sel_i = par; stop_sel_i = stp; start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        data_i = ~d; len_sel_i = ~len; par_sel_i = par ^ 2'b11; stop_sel_i = stp ^ 2'b01;
        push_n(1'b0, CPB, "R2/R6");
        for (int i = 0; i < nbits; i++) push_n(d[i], CPB, dtag);
        if (par == 2'd1 || par == 2'd2) push_n(pbit, CPB, "R4");
        push_n(1'b1, slen, "R5/R6");
        exp_q.push_back('{tx: 1'b1, busy: 1'b0, done: 1'b1, tag: "R7"});
        if (poke) begin
            repeat (2 * CPB) @(posedge clk);
            #1 start_i = 1'b1;
            @(posedge clk);
            #1 start_i = 1'b0;
            repeat (total - 2 * CPB - 1) @(posedge clk);
        end else begin
            repeat (total) @(posedge clk);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1 running = 1'b1;                       // R1: reset state checked by monitor
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        gap(4);
        send(8'hA5, 2'd3, 2'd0, 2'd0, 1'b0);    // 8N1
        gap(3);
        send(8'hFB, 2'd0, 2'd1, 2'd0, 1'b0);    // 5 bits even, upper bits unsent (R3, R4)
        gap(2);
        send(8'h2D, 2'd1, 2'd2, 2'd1, 1'b1);    // 6 bits odd, 1.5 stop, mid-frame strobe (R5, R9)
        send(8'h5C, 2'd2, 2'd1, 2'd2, 1'b0);    // back-to-back, 7 bits even, 2 stop
        send(8'h00, 2'd3, 2'd2, 2'd3, 1'b0);    // odd parity of zero is 1, stop code 3 (R4, R5)
        send(8'hFF, 2'd3, 2'd1, 2'd1, 1'b1);    // even parity of all ones is 0
        gap(5);
        send(8'h81, 2'd3, 2'd3, 2'd1, 1'b0);    // parity code 3 means none (R4)
        send(8'h1F, 2'd0, 2'd2, 2'd2, 1'b1);    // 5 bits odd
        gap(6);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule